// File: doc/BRIEF.md
# Three-Master Bus Arbiter with Configuration Override

This block decides which of three masters owns a shared synchronous on-chip bus. The three masters are a configuration engine, a bridge from an external processor, and user logic. Each master raises a request line. The current transfer reports its progress through three signals: a ready flag, a burst-in-progress flag and a lock flag. A static two-bit mode setting, loaded at configuration time, sets the relative priority of the processor bridge and the user logic.

A request from the configuration engine beats every other request. Between the other two masters, the winner is either fixed by the mode setting or chosen by rotation. Ownership changes only at a transfer boundary. The grant is registered, so a new owner sees its grant one clock after the boundary cycle in which the decision is made. When nobody requests, the bus stays parked on its last owner.

Top module: `bus_arb_top`

## Requirements
- R1: The grant vector is always one-hot. Bit 0 is the configuration master, bit 1 the processor bridge and bit 2 the user logic. After reset the grant is 3'b100 (user logic).
- R2: At a boundary, a request on bit 0 (configuration) wins over every other request, whatever the mode.
- R3: With mode 2'b01 and no configuration request, the processor bridge wins over the user logic.
- R4: With mode 2'b10 and no configuration request, the user logic wins over the processor bridge.
- R5: With mode 2'b00 or 2'b11, if both non-configuration masters request, the grant goes to the master named by the rotation pointer. The rotation order is processor bridge, then user logic, then processor bridge again.
- R6: The grant changes only in a boundary cycle. A boundary cycle has ready high, burst low and lock low. A configuration request also waits for a boundary.
- R7: The grant is registered. Outputs keep their old value for the rest of the boundary cycle and change at the next rising clock edge.
- R8: At a boundary with no requests, grant and owner stay on the last owner.
- R9: The rotation pointer is reset to the processor bridge. It moves to the other non-configuration master only when ownership passes to a non-configuration master that differs from the previous owner. Idle cycles, re-grants to the same owner and configuration grants leave it unchanged.
- R10: The owner output gives the index of the granted bit (0 = configuration, 1 = processor bridge, 2 = user logic) and always agrees with the grant vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 3 | Requests: bit 0 configuration, bit 1 processor bridge, bit 2 user logic |
| ready_i | input | 1 | Current transfer is ready |
| burst_i | input | 1 | Current owner has a burst in progress |
| lock_i | input | 1 | Current owner holds a locked sequence |
| prio_mode_i | input | 2 | 00/11 rotation, 01 processor bridge first, 10 user logic first |
| gnt_o | output | 3 | One-hot registered grant |
| owner_o | output | 2 | Index of the current owner |

## Verification
The configuration override and the boundary hold can fall in the same cycle. This happens when the configuration engine raises its request while another owner has a burst or lock in progress, or while ready is low. The bench raises that request during each of those three hold conditions. It expects the old grant to stay in place through all of them, including the part of the boundary cycle before the clock edge, and expects the configuration grant to appear exactly one edge after the first clean boundary. The pointer update and the override also meet when the configuration engine takes the bus from a rotation owner; the bench then checks that the next rotation decision still follows the pointer value from before the override.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int unsigned NUM_MST = 3;
  localparam int unsigned IDX_W   = $clog2(NUM_MST);

  typedef logic [NUM_MST-1:0] gnt_t;
  typedef logic [IDX_W-1:0]   idx_t;

  localparam idx_t MST_CFG = idx_t'(0);
  localparam idx_t MST_MPU = idx_t'(1);
  localparam idx_t MST_USR = idx_t'(2);

  typedef enum logic [1:0] {
    PRIO_RR     = 2'b00,
    PRIO_MPU    = 2'b01,
    PRIO_USR    = 2'b10,
    PRIO_RR_ALT = 2'b11
  } prio_mode_e;

  function automatic gnt_t idx2gnt(idx_t idx);
    gnt_t g;
    for (int i = 0; i < NUM_MST; i++) g[i] = (idx_t'(i) == idx);
    return g;
  endfunction
endpackage

// File: rtl/arb_boundary.sv
module arb_boundary (
  input  logic ready_i,
  input  logic burst_i,
  input  logic lock_i,
  output logic boundary_o
);
  assign boundary_o = ready_i & ~burst_i & ~lock_i;
endmodule

// File: rtl/arb_rr_ptr.sv
module arb_rr_ptr
  import bus_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  idx_t win_i,
  output idx_t ptr_o
);
  idx_t ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= MST_MPU;
    else if (upd_i) ptr_q <= (win_i == MST_MPU) ? MST_USR : MST_MPU;
  end

  assign ptr_o = ptr_q;

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ptr_q)); // R9
  AST_PTR_AFTER_MPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && win_i == MST_MPU) |=> (ptr_q == MST_USR)); // R9
endmodule

// File: rtl/arb_select.sv
module arb_select
  import bus_arb_pkg::*;
(
  input  gnt_t       req_i,
  input  logic [1:0] prio_mode_i,
  input  idx_t       ptr_i,
  input  idx_t       owner_i,
  output idx_t       win_o
);
  prio_mode_e mode;
  logic       both;

  assign mode = prio_mode_e'(prio_mode_i);
  assign both = req_i[MST_MPU] & req_i[MST_USR];

  always_comb begin
    win_o = owner_i;
    if (req_i[MST_CFG]) begin
      win_o = MST_CFG;
    end else if (both) begin
      unique case (mode)
        PRIO_MPU:            win_o = MST_MPU;
        PRIO_USR:            win_o = MST_USR;
        PRIO_RR, PRIO_RR_ALT: win_o = ptr_i;
        default:             win_o = ptr_i;
      endcase
    end else if (req_i[MST_MPU]) begin
      win_o = MST_MPU;
    end else if (req_i[MST_USR]) begin
      win_o = MST_USR;
    end
  end

  always_comb begin
    if (req_i[MST_CFG]) assert (win_o == MST_CFG); // R2
  end
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
  import bus_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       req_i,
  input  logic             ready_i,
  input  logic             burst_i,
  input  logic             lock_i,
  input  logic [1:0]       prio_mode_i,
  output logic [2:0]       gnt_o,
  output logic [1:0]       owner_o
);
  logic boundary;
  idx_t win, ptr, owner_q;
  gnt_t gnt_q;
  logic hand_over;

  arb_boundary u_bnd (
    .ready_i(ready_i), .burst_i(burst_i), .lock_i(lock_i), .boundary_o(boundary)
  );

  arb_select u_sel (
    .req_i(req_i), .prio_mode_i(prio_mode_i), .ptr_i(ptr),
    .owner_i(owner_q), .win_o(win)
  );

  assign hand_over = boundary && (win != owner_q);

  arb_rr_ptr u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .upd_i(hand_over && (win != MST_CFG)), .win_i(win), .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= MST_USR;
      gnt_q   <= idx2gnt(MST_USR);
    end else if (boundary) begin
      owner_q <= win;
      gnt_q   <= idx2gnt(win);
    end
  end

  assign gnt_o   = gnt_q;
  assign owner_o = owner_q;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(gnt_q)); // R1
  AST_CFG_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && req_i[MST_CFG]) |=> gnt_q[MST_CFG]); // R2
  AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(gnt_q)); // R6
  AST_PARK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && req_i == '0) |=> $stable(owner_q)); // R8
  AST_OWNER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q == (gnt_t'(1) << owner_q)); // R10
endmodule

// File: tb/sim_bus_arb_top.sv
module sim_bus_arb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req = '0;
  logic rdy = 1'b1, bst = 1'b0, lck = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] gnt;
  logic [1:0] own;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  bus_arb_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ready_i(rdy), .burst_i(bst),
    .lock_i(lck), .prio_mode_i(mode), .gnt_o(gnt), .owner_o(own)
  );

  task automatic chk(input string tag, input logic [2:0] eg, input logic [1:0] eo);
    checks++;
    if (gnt !== eg || own !== eo) begin
      errors++;
      $display("FAIL %s gnt=%b owner=%0d expected gnt=%b owner=%0d", tag, gnt, own, eg, eo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; rdy = 1'b1; bst = 1'b0; lck = 1'b0; mode = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic [2:0] r, input logic [1:0] m);
    req = r; mode = m;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 R10 reset park", 3'b100, 2'd2);
  endtask

  task automatic t_fixed();
    do_reset();
    step(3'b110, 2'b01); chk("R3 mpu first", 3'b010, 2'd1);
    step(3'b110, 2'b01); chk("R3 mpu kept", 3'b010, 2'd1);
    step(3'b110, 2'b10); chk("R4 usr first", 3'b100, 2'd2);
    step(3'b110, 2'b10); chk("R4 usr kept", 3'b100, 2'd2);
  endtask

  task automatic t_cfg();
    do_reset();
    step(3'b111, 2'b01); chk("R2 cfg over mode01", 3'b001, 2'd0);
    step(3'b111, 2'b10); chk("R2 cfg over mode10", 3'b001, 2'd0);
  endtask

  task automatic t_hold();
    do_reset();
    bst = 1'b1; step(3'b011, 2'b01); chk("R6 burst holds cfg", 3'b100, 2'd2);
    bst = 1'b0; lck = 1'b1; step(3'b011, 2'b01); chk("R6 lock holds", 3'b100, 2'd2);
    lck = 1'b0; rdy = 1'b0; step(3'b011, 2'b01); chk("R6 not ready holds", 3'b100, 2'd2);
    rdy = 1'b1; req = 3'b011;
    #2 chk("R7 old grant in boundary cycle", 3'b100, 2'd2);
    @(negedge clk); chk("R7 R2 grant after edge", 3'b001, 2'd0);
  endtask

  task automatic t_park();
    do_reset();
    step(3'b010, 2'b01); chk("R8 grant mpu", 3'b010, 2'd1);
    step(3'b000, 2'b01); chk("R8 park idle 1", 3'b010, 2'd1);
    step(3'b000, 2'b00); chk("R8 park idle 2", 3'b010, 2'd1);
  endtask

  task automatic t_rr(input logic [1:0] m, input string tag);
    do_reset();
    step(3'b110, m); chk({tag, " rr first mpu"}, 3'b010, 2'd1);
    step(3'b110, m); chk({tag, " rr then usr"}, 3'b100, 2'd2);
    step(3'b110, m); chk({tag, " rr back mpu"}, 3'b010, 2'd1);
  endtask

  task automatic t_rr_idle();
    do_reset();
    step(3'b100, 2'b00); chk("R9 regrant usr", 3'b100, 2'd2);
    step(3'b000, 2'b00);
    step(3'b100, 2'b00);
    step(3'b110, 2'b00); chk("R9 ptr unmoved by idle", 3'b010, 2'd1);
  endtask

  task automatic t_cfg_ptr();
    do_reset();
    step(3'b110, 2'b00); chk("R5 mpu", 3'b010, 2'd1);
    step(3'b001, 2'b00); chk("R2 cfg takes", 3'b001, 2'd0);
    step(3'b110, 2'b00); chk("R9 ptr kept across cfg", 3'b100, 2'd2);
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fixed();
    t_cfg();
    t_hold();
    t_park();
    t_rr(2'b00, "R5 mode00");
    t_rr(2'b11, "R5 mode11");
    t_rr_idle();
    t_cfg_ptr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule